// File: doc/BRIEF.md
# Tag-Loaded Locked Code Bank

This block is a directly addressed 4 KB store of program words that sits next to an instruction cache. It holds 256 lines of four 32-bit words and one programmable 12-bit tag that names a single contiguous 4 KB window of external memory. Software writes the tag, and the bank then loads all 256 lines from that window by itself, one four-word burst per line. CPU fetches are held off until the load is over.

Each fetch address is split into three fields. Bits 23-12 are compared with the tag, bits 11-4 select a line and bits 3-2 select a word. When the tag matches, the bank owns the fetch. A valid line answers in the same cycle. An invalid line is reloaded on its own, and the wanted word is passed to the CPU as it arrives. The neighbouring two-way cache uses the claim output to stay out of any fetch the bank owns. A flush drops every line and the tag-valid flag. It keeps the tag, so later fetches inside the window reload lines one at a time.

Top module: `locked_code_bank`

## Requirements
- R1: A fetch address divides as tag = bits 23-12, line = bits 11-4, word = bits 3-2; bits 1-0 are ignored. A fetch whose bits 23-12 differ from the tag gets neither `bank_claim` nor `word_ok`.
- R2: `tag_q` returns the written tag in bits 11-0 and zero in bits 15-12, whatever was written to `tag_wdata[15:12]`.
- R3: An accepted tag write starts a fill. The fill issues 256 line requests, with line numbers rising from 0 to 255. Each `mem_addr` is {tag, line, 4'b0000}, and each line becomes valid once its fourth word arrives.
- R4: `tag_valid` is 0 out of reset. It goes to 0 in the cycle after a tag write and rises only after the last line of the fill has arrived.
- R5: While a fill runs, `fetch_stall` is 1 and no fetch receives `word_ok`.
- R6: A fetch with a matching tag whose line is valid gets `word_ok` in the same cycle. `word_out` then holds the external word at that address.
- R7: A fetch with a matching tag whose line is invalid sends exactly one line request for that line. `word_ok` comes with the requested word as it arrives from memory. Afterwards the line hits, and other lines stay invalid.
- R8: `bank_claim` is 1 for every enabled fetch that matches the tag, whether or not the line is valid, so the two-way cache is not filled for it.
- R9: A flush clears every line valid bit and `tag_valid`. After it, no fetch hits until its line has been reloaded.
- R10: A tag write while `en` is 0 is ignored: no fill starts and `tag_q` does not change.
- R11: A tag write that lands during a fill abandons that fill. The next fill starts at line 0 with the new tag, and only the new window's words are served.
- R12: While `en` is 0, fetches get neither `bank_claim` nor `word_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Cache enable; gates tag writes and lookups |
| flush | input | 1 | One-cycle pulse that invalidates all lines and tag-valid |
| tag_wr | input | 1 | One-cycle tag register write strobe |
| tag_wdata | input | 16 | Tag write data, tag in bits 11-0 |
| tag_q | output | 16 | Tag register readback, bits 15-12 zero |
| tag_valid | output | 1 | Set once a full fill has completed |
| filling | output | 1 | Bulk fill in progress |
| fetch_req | input | 1 | CPU fetch request |
| fetch_addr | input | 24 | CPU byte fetch address |
| bank_claim | output | 1 | Fetch falls in the bank window; two-way cache must not allocate |
| bank_hit | output | 1 | Fetch served from a valid line this cycle |
| word_ok | output | 1 | `word_out` carries the requested word this cycle |
| word_out | output | 32 | Requested word |
| fetch_stall | output | 1 | Bank busy with a fill or a line reload |
| mem_req | output | 1 | One-cycle request for a four-word line burst |
| mem_addr | output | 24 | Line-aligned burst address |
| mem_rvalid | input | 1 | One burst word is present |
| mem_rdata | input | 32 | Burst word, lowest address first |

## Verification
The lookup is exercised in several ways: random line and word offsets under a matching tag, random tags that differ from the loaded one, and a fetch to a line emptied by a flush. These separate a hit, a foreign address and a reload miss. The fill order is recorded for a clean fill and for a fill that a second tag write cuts off. This shows whether the restart really begins at line 0 and whether stale bursts stay out of the array. The memory model picks a random latency for every burst, so any hidden dependence on when words arrive shows up.

// File: rtl/locked_code_bank.sv
`timescale 1ns/1ps
module locked_code_bank #(
  parameter int LINES  = 256,
  parameter int WPL    = 4,
  parameter int TAG_W  = 12,
  parameter int AW     = 24,
  parameter int DW     = 32,
  parameter int TREG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              flush,
  input  logic              tag_wr,
  input  logic [TREG_W-1:0] tag_wdata,
  output logic [TREG_W-1:0] tag_q,
  output logic              tag_valid,
  output logic              filling,
  input  logic              fetch_req,
  input  logic [AW-1:0]     fetch_addr,
  output logic              bank_claim,
  output logic              bank_hit,
  output logic              word_ok,
  output logic [DW-1:0]     word_out,
  output logic              fetch_stall,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int LW = $clog2(LINES);
  localparam int OW = $clog2(WPL);
  localparam int BW = $clog2(DW/8);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_LOAD} state_t;

  state_t           state;
  logic [TAG_W-1:0] tag;
  logic             bound, tv, inflight, keep;
  logic [LINES-1:0] lv;
  logic [LW-1:0]    cur_line;
  logic [OW-1:0]    wc, ld_off;
  logic [DW-1:0]    arr [LINES*WPL];

  wire [TAG_W-1:0] f_tag  = fetch_addr[AW-1 -: TAG_W];
  wire [LW-1:0]    f_line = fetch_addr[BW+OW +: LW];
  wire [OW-1:0]    f_off  = fetch_addr[BW +: OW];
  wire             last   = (wc == OW'(WPL-1));
  wire             take   = mem_rvalid && inflight;
  wire             load_word = (state == S_LOAD) && take && keep && (wc == ld_off);

  assign tag_q       = {{(TREG_W-TAG_W){1'b0}}, tag};
  assign tag_valid   = tv;
  assign filling     = (state == S_FILL);
  assign fetch_stall = (state != S_IDLE);
  assign bank_claim  = en && fetch_req && bound && (f_tag == tag);
  assign bank_hit    = bank_claim && lv[f_line] && (state == S_IDLE);
  assign word_ok     = bank_hit || load_word;
  assign word_out    = load_word ? mem_rdata : arr[{f_line, f_off}];
  assign mem_req     = (state != S_IDLE) && !inflight;
  assign mem_addr    = {tag, cur_line, {(OW+BW){1'b0}}};

  always_ff @(posedge clk)
    if (take && keep) arr[{cur_line, wc}] <= mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tag      <= '0;
      bound    <= 1'b0;
      tv       <= 1'b0;
      inflight <= 1'b0;
      keep     <= 1'b0;
      lv       <= '0;
      cur_line <= '0;
      wc       <= '0;
      ld_off   <= '0;
    end else begin
      if (mem_req) begin
        inflight <= 1'b1;
        keep     <= 1'b1;
        wc       <= '0;
      end
      if (take) begin
        wc <= wc + 1'b1;
        if (last) begin
          inflight <= 1'b0;
          if (keep) begin
            lv[cur_line] <= 1'b1;
            if (state == S_FILL) begin
              if (cur_line == LW'(LINES-1)) begin
                state <= S_IDLE;
                tv    <= 1'b1;
              end else cur_line <= cur_line + 1'b1;
            end else state <= S_IDLE;
          end
        end
      end
      if (state == S_IDLE && bank_claim && !lv[f_line]) begin
        state    <= S_LOAD;
        cur_line <= f_line;
        ld_off   <= f_off;
      end
      if (flush) begin
        lv    <= '0;
        tv    <= 1'b0;
        keep  <= 1'b0;
        state <= S_IDLE;
      end
      if (tag_wr && en) begin
        tag      <= tag_wdata[TAG_W-1:0];
        bound    <= 1'b1;
        lv       <= '0;
        tv       <= 1'b0;
        keep     <= 1'b0;
        state    <= S_FILL;
        cur_line <= '0;
      end
    end
  end

  AST_TAGWR_STARTS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tag_wr) |=> (filling && !tag_valid)); // R3
  AST_NO_TV_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> !tag_valid); // R4
  AST_TV_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_valid) |-> $past(filling)); // R4
  AST_NO_WORD_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> !word_ok); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !(en && tag_wr)) |=> (lv == '0 && !tag_valid)); // R9
  AST_DISABLED_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && tag_wr) |=> $stable(tag_q)); // R10
  AST_DISABLED_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!bank_claim && !bank_hit)); // R12
endmodule

// File: tb/locked_code_bank_test.sv
`timescale 1ns/1ps
module locked_code_bank_test;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, flush = 1'b0, tag_wr = 1'b0;
  logic [15:0] tag_wdata = '0;
  logic [15:0] tag_q;
  logic        tag_valid, filling, bank_claim, bank_hit, word_ok, fetch_stall, mem_req;
  logic        fetch_req = 1'b0;
  logic [23:0] fetch_addr = '0, mem_addr;
  logic [31:0] word_out;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int compared = 0, mismatched = 0, cyc = 0;
  int trk_n = 0, trk_err = 0;
  logic [11:0] trk_tag = '0;
  logic [7:0]  trk_line = '0;

  logic        m_busy = 1'b0;
  logic [23:0] m_base = '0;
  logic [1:0]  m_beat = '0;
  int          m_dly = 0;

  locked_code_bank uut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] ext(input logic [23:0] a);
    return ({8'h0, a[23:2], 2'b00} * 32'h9E3779B1) ^ 32'h1F2E3D4C;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (m_busy) begin
      if (m_dly > 0) m_dly <= m_dly - 1;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= ext({m_base[23:4], m_beat, 2'b00});
        m_beat     <= m_beat + 2'd1;
        if (m_beat == 2'd3) m_busy <= 1'b0;
      end
    end else if (mem_req) begin
      m_busy <= 1'b1;
      m_base <= mem_addr;
      m_beat <= 2'd0;
      m_dly  <= $urandom_range(0, 2);
    end
  end

  always @(posedge clk)
    if (rst_n && mem_req && mem_addr[23:12] == trk_tag) begin
      if (mem_addr[11:4] != trk_line || mem_addr[3:0] != 4'h0) trk_err <= trk_err + 1;
      trk_line <= trk_line + 8'd1;
      trk_n    <= trk_n + 1;
    end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic write_tag(input logic [11:0] t);
    @(negedge clk);
    tag_wr = 1'b1;
    tag_wdata = {4'hF, t};
    @(negedge clk);
    tag_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (fetch_stall && n < 20000) begin
      @(negedge clk);
      n++;
    end
    #1;
  endtask

  task automatic probe(input logic [11:0] t, input logic [7:0] ln, input logic [1:0] of);
    fetch_addr = {t, ln, of, 2'($urandom)};
    fetch_req = 1'b1;
    #1;
  endtask

  task automatic hits(input logic [11:0] t, input int count, input string rq);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      probe(t, 8'($urandom), 2'($urandom));
      chk(word_ok && bank_claim, rq, {30'd0, word_ok, bank_claim}, 32'd3);
      chk(word_out == ext(fetch_addr), rq, word_out, ext(fetch_addr));
      fetch_req = 1'b0;
    end
  endtask

  initial begin
    logic [11:0] tag_a, tag_b, tag_c, t;
    bit got;
    void'($urandom(32'd4242));
    tag_a = 12'h3C5;
    tag_b = 12'h81A;
    tag_c = 12'h0F7;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!tag_valid, "R4 reset tag_valid", tag_valid, 0);
    chk(!fetch_stall, "R5 reset stall", fetch_stall, 0);
    chk(!mem_req, "R3 reset mem_req", mem_req, 0);
    chk(tag_q == 16'h0, "R2 reset tag_q", tag_q, 0);

    en = 1'b1;
    trk_tag = tag_a; trk_line = '0; trk_n = 0; trk_err = 0;
    write_tag(tag_a);
    #1;
    chk(!tag_valid, "R4 cleared on tag write", tag_valid, 0);
    chk(filling, "R3 fill started", filling, 1);
    repeat (20) @(negedge clk);
    probe(tag_a, 8'd0, 2'd0);
    chk(!word_ok && fetch_stall, "R5 no word during fill", {30'd0, word_ok, fetch_stall}, 32'd1);
    fetch_req = 1'b0;
    wait_idle();
    chk(tag_valid, "R4 set after fill", tag_valid, 1);
    chk(trk_n == 256, "R3 line request count", trk_n, 256);
    chk(trk_err == 0, "R3 ascending line order", trk_err, 0);
    chk(tag_q == {4'h0, tag_a}, "R2 tag readback", tag_q, {4'h0, tag_a});

    hits(tag_a, 40, "R6 R1 R8 hit data");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      t = tag_a ^ 12'(1 + $urandom % 4095);
      probe(t, 8'($urandom), 2'($urandom));
      chk(!bank_claim && !word_ok, "R1 foreign tag", {30'd0, bank_claim, word_ok}, 0);
      fetch_req = 1'b0;
    end

    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    #1;
    chk(!tag_valid, "R9 flush clears tag_valid", tag_valid, 0);
    trk_tag = tag_a; trk_line = 8'd5; trk_n = 0; trk_err = 0;
    @(negedge clk);
    probe(tag_a, 8'd5, 2'd1);
    chk(!bank_hit, "R9 no hit after flush", bank_hit, 0);
    chk(bank_claim && !word_ok, "R7 R8 claim on invalid line", {30'd0, bank_claim, word_ok}, 32'd2);
    got = 1'b0;
    for (int n = 0; n < 60 && !got; n++) begin
      @(negedge clk);
      #1;
      if (word_ok) begin
        got = 1'b1;
        chk(word_out == ext(fetch_addr), "R7 reloaded word", word_out, ext(fetch_addr));
      end
    end
    chk(got, "R7 word delivered", got, 1);
    fetch_req = 1'b0;
    wait_idle();
    chk(trk_n == 1 && trk_err == 0, "R7 single line request", trk_n, 1);
    @(negedge clk);
    probe(tag_a, 8'd5, 2'd3);
    chk(word_ok && word_out == ext(fetch_addr), "R7 line hits after reload", word_out, ext(fetch_addr));
    fetch_req = 1'b0;
    @(negedge clk);
    probe(tag_a, 8'd6, 2'd0);
    chk(bank_claim && !word_ok, "R7 neighbour still invalid", {30'd0, bank_claim, word_ok}, 32'd2);
    fetch_req = 1'b0;

    en = 1'b0;
    write_tag(tag_b);
    #1;
    chk(!fetch_stall, "R10 no fill when disabled", fetch_stall, 0);
    chk(tag_q == {4'h0, tag_a}, "R10 tag unchanged", tag_q, {4'h0, tag_a});
    @(negedge clk);
    probe(tag_a, 8'd5, 2'd3);
    chk(!bank_claim && !word_ok, "R12 disabled lookup", {30'd0, bank_claim, word_ok}, 0);
    fetch_req = 1'b0;

    en = 1'b1;
    write_tag(tag_b);
    repeat (37) @(negedge clk);
    #1;
    chk(filling, "R11 first fill running", filling, 1);
    trk_tag = tag_c; trk_line = '0; trk_n = 0; trk_err = 0;
    write_tag(tag_c);
    #1;
    chk(filling && !tag_valid, "R11 restarted fill", {30'd0, filling, tag_valid}, 32'd2);
    wait_idle();
    chk(trk_n == 256, "R11 new window request count", trk_n, 256);
    chk(trk_err == 0, "R11 restart from line 0", trk_err, 0);
    chk(tag_q == {4'h0, tag_c}, "R11 new tag", tag_q, {4'h0, tag_c});
    hits(tag_c, 20, "R11 new window data");
    @(negedge clk);
    probe(tag_b, 8'($urandom), 2'($urandom));
    chk(!bank_claim, "R11 abandoned window", bank_claim, 0);
    fetch_req = 1'b0;

    repeat (3) @(negedge clk);
    summary();
  end
endmodule